// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This unit watches every bus cycle presented on its monitor port and raises a break request for the debug logic when a programmed condition is met. It has two comparison channels, A and B. Each compares the cycle address under a per-bit don't-care mask, the access direction, the access kind (instruction fetch or data) and the class of bus master (CPU, or peripheral: a DMA engine or an external master). Channel B can also require an exact match of the data value.

The two channels raise breaks on their own or are chained, so that channel B only breaks once channel A has matched. Sticky match flags record which channel matched which class of cycle. A timing bit tells the exception logic whether a fetch break is taken before or after the instruction. Software programs the unit through a simple indexed register write port with a combinational read. The unit only asserts the request. Stalling the pipeline and entering the exception are done elsewhere.

The monitor port is a valid-qualified stream with no ready signal. The comparator never applies back-pressure, and each beat with `mon_valid` high is evaluated in the cycle it is presented. Two resets exist. `por_n` clears all registers. `mrst_n` clears only the sequencing state and the break outputs.

Top module: `bus_break_unit`

## Requirements
- R1: While `por_n` is low the control register (index 0) reads 0x0000 and `brk_req` is 0. A pulse on `mrst_n` leaves every register unchanged but discards a pending sequence arm.
- R2: A channel's address matches when every address bit whose mask bit is 0 equals the stored address. Mask bits set to 1 are don't-care.
- R3: The condition register holds three 2-bit selectors. Bits [1:0] are the direction (bit0 read, bit1 write). Bits [3:2] are the kind (bit2 fetch, bit3 data). Bits [5:4] are the class (bit4 CPU, bit5 peripheral). A cycle matches only if its direction, kind and class are all enabled, so a selector of 00 turns the channel off.
- R4: `brk_req` is high for exactly the one cycle after a qualifying monitor beat and is low otherwise.
- R5: Control bits 15 and 14 are sticky flags for channel A matching a CPU or a peripheral cycle. Bits 12 and 11 are the same flags for channel B. Hardware only ever sets them.
- R6: Writing 0 to a flag clears it and writing 1 leaves it unchanged. A hardware set in the same cycle wins.
- R7: Control bit 13 enables external breaks. Master code 2 (external) counts as a peripheral cycle only when this bit is set, and is ignored otherwise. Master code 0 is the CPU and code 1 is DMA.
- R8: Control bit 1 adds an exact comparison of `mon_data` with the channel B data register (index 7) to channel B's condition.
- R9: With control bit 3 set (sequential), a channel A match arms the sequence and raises no break. A channel B match while armed breaks and disarms. A channel B match while not armed raises no break. Any control-register write disarms.
- R10: With control bit 2 set, `brk_after` is high together with `brk_req` when the triggering beat was a fetch, meaning the break is taken after execution. Otherwise `brk_after` stays 0.
- R11: Control bit 0 selects the legacy-compatible mode. In this mode the channels always break independently and channel B's data comparison is ignored.
- R12: A beat with `mon_valid` low neither breaks nor sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low; clears sequencing and break outputs only |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: 0 control, 1/2/3 A address/mask/condition, 4/5/6 B address/mask/condition, 7 B data |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Read data of the register selected by `reg_idx` (combinational) |
| mon_valid | input | 1 | Monitor beat valid |
| mon_addr | input | W | Monitored cycle address |
| mon_data | input | W | Monitored cycle data |
| mon_write | input | 1 | 1 for a write cycle, 0 for a read |
| mon_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| mon_master | input | 2 | Bus master code: 0 CPU, 1 DMA, 2 external |
| brk_req | output | 1 | One-cycle break request |
| brk_after | output | 1 | Break is to be taken after the fetched instruction executes |

## Verification
The assertions assume that `por_n` is low at the first clock edge. They also assume that the monitor fields are stable for the whole cycle in which `mon_valid` is high. The sticky-flag and disarm properties treat a control write as the only software action that may change those bits. The bench therefore drives every input at the falling edge and asserts power-on reset from time zero. It pulses the manual reset only between beats, so each beat and each register write settles a half cycle before the edge that samples it.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  localparam int IDX_W  = 3;
  localparam int CTRL_W = 16;

  // control register bit positions
  localparam int C_FLAG_ACPU = 15;
  localparam int C_FLAG_APER = 14;
  localparam int C_EXT_EN    = 13;
  localparam int C_FLAG_BCPU = 12;
  localparam int C_FLAG_BPER = 11;
  localparam int C_SEQ       = 3;
  localparam int C_AFTER     = 2;
  localparam int C_DCMP      = 1;
  localparam int C_LEGACY    = 0;

  localparam logic [CTRL_W-1:0] FLAG_MASK =
    (16'd1 << C_FLAG_ACPU) | (16'd1 << C_FLAG_APER) |
    (16'd1 << C_FLAG_BCPU) | (16'd1 << C_FLAG_BPER);
  localparam logic [CTRL_W-1:0] CFG_MASK =
    (16'd1 << C_EXT_EN) | (16'd1 << C_SEQ) | (16'd1 << C_AFTER) |
    (16'd1 << C_DCMP) | (16'd1 << C_LEGACY);

  typedef enum logic [1:0] {
    MST_CPU = 2'd0,
    MST_DMA = 2'd1,
    MST_EXT = 2'd2,
    MST_RSV = 2'd3
  } master_e;

  typedef enum logic [IDX_W-1:0] {
    RI_CTRL  = 3'd0,
    RI_AADDR = 3'd1,
    RI_AMASK = 3'd2,
    RI_ACOND = 3'd3,
    RI_BADDR = 3'd4,
    RI_BMASK = 3'd5,
    RI_BCOND = 3'd6,
    RI_BDATA = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic [1:0] cls;   // [1] peripheral, [0] CPU
    logic [1:0] kind;  // [1] data, [0] fetch
    logic [1:0] dir;   // [1] write, [0] read
  } cond_t;
endpackage

// File: rtl/bbu_channel.sv
module bbu_channel
  import bbu_pkg::*;
#(
  parameter int W        = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic [W-1:0] ref_addr,
  input  logic [W-1:0] ref_mask,
  input  cond_t        cond,
  input  logic [W-1:0] ref_data,
  input  logic         data_en,
  input  logic         mon_valid,
  input  logic [W-1:0] mon_addr,
  input  logic [W-1:0] mon_data,
  input  logic         mon_write,
  input  logic         mon_fetch,
  input  logic         is_cpu,
  input  logic         is_per,
  output logic         hit_cpu,
  output logic         hit_per
);
  logic addr_ok, dir_ok, kind_ok, data_ok, base;

  always_comb begin
    addr_ok = ((mon_addr ^ ref_addr) & ~ref_mask) == '0;
    dir_ok  = mon_write ? cond.dir[1]  : cond.dir[0];
    kind_ok = mon_fetch ? cond.kind[0] : cond.kind[1];
    data_ok = !(HAS_DATA && data_en) || (mon_data == ref_data);
    base    = mon_valid && addr_ok && dir_ok && kind_ok && data_ok;
    hit_cpu = base && is_cpu && cond.cls[0];
    hit_per = base && is_per && cond.cls[1];
  end
endmodule

// File: rtl/bbu_regs.sv
module bbu_regs
  import bbu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [W-1:0]      wdata,
  input  logic              set_acpu,
  input  logic              set_aper,
  input  logic              set_bcpu,
  input  logic              set_bper,
  output logic [CTRL_W-1:0] ctrl,
  output logic [W-1:0]      a_addr,
  output logic [W-1:0]      a_mask,
  output cond_t             a_cond,
  output logic [W-1:0]      b_addr,
  output logic [W-1:0]      b_mask,
  output cond_t             b_cond,
  output logic [W-1:0]      b_data,
  output logic [W-1:0]      rdata
);
  localparam int COND_W = $bits(cond_t);

  logic [CTRL_W-1:0] sets;
  logic [CTRL_W-1:0] wr16;

  always_comb begin
    sets = '0;
    sets[C_FLAG_ACPU] = set_acpu;
    sets[C_FLAG_APER] = set_aper;
    sets[C_FLAG_BCPU] = set_bcpu;
    sets[C_FLAG_BPER] = set_bper;
    wr16 = wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl   <= '0;
      a_addr <= '0;
      a_mask <= '0;
      a_cond <= '0;
      b_addr <= '0;
      b_mask <= '0;
      b_cond <= '0;
      b_data <= '0;
    end else begin
      if (wr_en && idx == RI_CTRL)
        ctrl <= (wr16 & CFG_MASK) | (ctrl & wr16 & FLAG_MASK) | sets;
      else
        ctrl <= ctrl | sets;
      if (wr_en) begin
        case (reg_idx_e'(idx))
          RI_AADDR: a_addr <= wdata;
          RI_AMASK: a_mask <= wdata;
          RI_ACOND: a_cond <= cond_t'(wdata[COND_W-1:0]);
          RI_BADDR: b_addr <= wdata;
          RI_BMASK: b_mask <= wdata;
          RI_BCOND: b_cond <= cond_t'(wdata[COND_W-1:0]);
          RI_BDATA: b_data <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_idx_e'(idx))
      RI_CTRL:  rdata = {{(W-CTRL_W){1'b0}}, ctrl};
      RI_AADDR: rdata = a_addr;
      RI_AMASK: rdata = a_mask;
      RI_ACOND: rdata = {{(W-COND_W){1'b0}}, a_cond};
      RI_BADDR: rdata = b_addr;
      RI_BMASK: rdata = b_mask;
      RI_BCOND: rdata = {{(W-COND_W){1'b0}}, b_cond};
      default:  rdata = b_data;
    endcase
  end
endmodule

// File: rtl/bbu_seq.sv
module bbu_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic a_hit,
  input  logic b_hit,
  input  logic seq_mode,
  input  logic ctrl_wr,
  input  logic fetch_after,
  input  logic mon_fetch,
  output logic brk_req,
  output logic brk_after,
  output logic armed
);
  logic fire;
  logic arm_nxt;

  always_comb begin
    fire = seq_mode ? (armed && b_hit) : (a_hit || b_hit);
    if (ctrl_wr || !seq_mode)      arm_nxt = 1'b0;
    else if (armed && b_hit)       arm_nxt = 1'b0;
    else if (a_hit)                arm_nxt = 1'b1;
    else                           arm_nxt = armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      brk_req   <= 1'b0;
      brk_after <= 1'b0;
    end else begin
      armed     <= arm_nxt;
      brk_req   <= fire;
      brk_after <= fire && mon_fetch && fetch_after;
    end
  end
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mrst_n,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic             mon_valid,
  input  logic [W-1:0]     mon_addr,
  input  logic [W-1:0]     mon_data,
  input  logic             mon_write,
  input  logic             mon_fetch,
  input  logic [1:0]       mon_master,
  output logic             brk_req,
  output logic             brk_after
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      a_addr, a_mask, b_addr, b_mask, b_data;
  cond_t             a_cond, b_cond;
  logic              a_cpu, a_per, b_cpu, b_per;
  logic              is_cpu, is_per, legacy, seq_mode, dcmp, ctrl_wr;
  logic              seq_rst_n, seq_armed;

  always_comb begin
    legacy   = ctrl_q[C_LEGACY];
    seq_mode = ctrl_q[C_SEQ] && !legacy;
    dcmp     = ctrl_q[C_DCMP] && !legacy;
    is_cpu   = master_e'(mon_master) == MST_CPU;
    is_per   = master_e'(mon_master) == MST_DMA ||
               (master_e'(mon_master) == MST_EXT && ctrl_q[C_EXT_EN]);
    ctrl_wr  = reg_wr && reg_idx == RI_CTRL;
    seq_rst_n = por_n && mrst_n;
  end

  bbu_regs #(.W(W)) u_regs (
    .clk      (clk),
    .por_n    (por_n),
    .wr_en    (reg_wr),
    .idx      (reg_idx),
    .wdata    (reg_wdata),
    .set_acpu (a_cpu),
    .set_aper (a_per),
    .set_bcpu (b_cpu),
    .set_bper (b_per),
    .ctrl     (ctrl_q),
    .a_addr   (a_addr),
    .a_mask   (a_mask),
    .a_cond   (a_cond),
    .b_addr   (b_addr),
    .b_mask   (b_mask),
    .b_cond   (b_cond),
    .b_data   (b_data),
    .rdata    (reg_rdata)
  );

  bbu_channel #(.W(W), .HAS_DATA(1'b0)) u_chan_a (
    .ref_addr  (a_addr),
    .ref_mask  (a_mask),
    .cond      (a_cond),
    .ref_data  (b_data),
    .data_en   (1'b0),
    .mon_valid (mon_valid),
    .mon_addr  (mon_addr),
    .mon_data  (mon_data),
    .mon_write (mon_write),
    .mon_fetch (mon_fetch),
    .is_cpu    (is_cpu),
    .is_per    (is_per),
    .hit_cpu   (a_cpu),
    .hit_per   (a_per)
  );

  bbu_channel #(.W(W), .HAS_DATA(1'b1)) u_chan_b (
    .ref_addr  (b_addr),
    .ref_mask  (b_mask),
    .cond      (b_cond),
    .ref_data  (b_data),
    .data_en   (dcmp),
    .mon_valid (mon_valid),
    .mon_addr  (mon_addr),
    .mon_data  (mon_data),
    .mon_write (mon_write),
    .mon_fetch (mon_fetch),
    .is_cpu    (is_cpu),
    .is_per    (is_per),
    .hit_cpu   (b_cpu),
    .hit_per   (b_per)
  );

  bbu_seq u_seq (
    .clk         (clk),
    .rst_n       (seq_rst_n),
    .a_hit       (a_cpu || a_per),
    .b_hit       (b_cpu || b_per),
    .seq_mode    (seq_mode),
    .ctrl_wr     (ctrl_wr),
    .fetch_after (ctrl_q[C_AFTER]),
    .mon_fetch   (mon_fetch),
    .brk_req     (brk_req),
    .brk_after   (brk_after),
    .armed       (seq_armed)
  );
endmodule

// File: rtl/bbu_chk.sv
module bbu_chk (
  input logic        clk,
  input logic        por_n,
  input logic        reg_wr,
  input logic [2:0]  reg_idx,
  input logic        mon_valid,
  input logic        brk_req,
  input logic        brk_after,
  input logic [15:0] ctrl,
  input logic        armed
);
  AST_POR_ZERO: assert property (@(posedge clk) !por_n |-> (ctrl == 16'h0000 && !brk_req)); // R1

  AST_BRK_FROM_BEAT: assert property (@(posedge clk) disable iff (!por_n)
    brk_req |-> $past(mon_valid)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    ($past(ctrl[15]) && !$past(reg_wr && reg_idx == 3'd0)) |-> ctrl[15]); // R5

  AST_ARM_DROP_ON_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    $past(reg_wr && reg_idx == 3'd0) |-> !armed); // R9

  AST_AFTER_NEEDS_BRK: assert property (@(posedge clk) disable iff (!por_n)
    brk_after |-> brk_req); // R10

  AST_LEGACY_NO_ARM: assert property (@(posedge clk) disable iff (!por_n)
    ctrl[0] |-> !armed); // R11
endmodule

bind bus_break_unit bbu_chk u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .reg_wr    (reg_wr),
  .reg_idx   (reg_idx),
  .mon_valid (mon_valid),
  .brk_req   (brk_req),
  .brk_after (brk_after),
  .ctrl      (ctrl_q),
  .armed     (seq_armed)
);

// File: tb/sim_bus_break_unit.sv
`timescale 1ns/1ps
module sim_bus_break_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         por_n = 1'b0;
  logic         mrst_n = 1'b1;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_idx = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         mon_valid = 1'b0;
  logic [W-1:0] mon_addr = '0;
  logic [W-1:0] mon_data = '0;
  logic         mon_write = 1'b0;
  logic         mon_fetch = 1'b0;
  logic [1:0]   mon_master = 2'd0;
  logic         brk_req, brk_after;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_break_unit #(.W(W)) u0 (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mon_valid(mon_valid), .mon_addr(mon_addr), .mon_data(mon_data),
    .mon_write(mon_write), .mon_fetch(mon_fetch), .mon_master(mon_master),
    .brk_req(brk_req), .brk_after(brk_after)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] cond(input logic [1:0] cls, input logic [1:0] kind,
                                        input logic [1:0] dir);
    return {{(W-6){1'b0}}, cls, kind, dir};
  endfunction

  task automatic wr(input logic [2:0] idx, input logic [W-1:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [W-1:0] val);
    @(negedge clk);
    reg_idx = idx;
    #1 val = reg_rdata;
  endtask

  task automatic beat(input logic [W-1:0] a, input logic [W-1:0] d, input logic w,
                      input logic f, input logic [1:0] m,
                      output logic brk, output logic aft);
    @(negedge clk);
    mon_valid = 1'b1; mon_addr = a; mon_data = d;
    mon_write = w; mon_fetch = f; mon_master = m;
    @(posedge clk);
    #1 brk = brk_req; aft = brk_after;
    @(negedge clk);
    mon_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    #1 check("R1", "brk_req during power-on reset", {31'd0, brk_req}, 0);
    @(negedge clk); @(negedge clk);
    v = reg_rdata;
    check("R1", "control during power-on reset", v, 0);
    por_n = 1'b1;
    rd(3'd0, v);
    check("R1", "control after power-on reset", v, 0);
  endtask

  task automatic t_mask();
    logic b, a;
    wr(3'd1, 32'h1000_0040); wr(3'd2, 32'h0000_000F); wr(3'd3, 32'h3F);
    beat(32'h1000_004C, 0, 0, 0, 2'd0, b, a);
    check("R2", "masked address bits ignored", {31'd0, b}, 1);
    @(posedge clk); #1
    check("R4", "break is a single-cycle pulse", {31'd0, brk_req}, 0);
    beat(32'h1000_0050, 0, 0, 0, 2'd0, b, a);
    check("R2", "unmasked address bit differs", {31'd0, b}, 0);
  endtask

  task automatic t_fields();
    logic b, a;
    wr(3'd1, 32'h0000_0300); wr(3'd2, 0);
    wr(3'd3, cond(2'b01, 2'b10, 2'b10)); // CPU, data, write
    beat(32'h300, 0, 0, 0, 2'd0, b, a);
    check("R3", "read rejected by write-only selector", {31'd0, b}, 0);
    beat(32'h300, 0, 1, 1, 2'd0, b, a);
    check("R3", "fetch rejected by data-only selector", {31'd0, b}, 0);
    beat(32'h300, 0, 1, 0, 2'd1, b, a);
    check("R3", "DMA rejected by CPU-only selector", {31'd0, b}, 0);
    beat(32'h300, 0, 1, 0, 2'd0, b, a);
    check("R3", "all selectors satisfied", {31'd0, b}, 1);
    wr(3'd3, cond(2'b00, 2'b11, 2'b11));
    beat(32'h300, 0, 1, 0, 2'd0, b, a);
    check("R3", "class selector 00 disables channel", {31'd0, b}, 0);
  endtask

  task automatic t_flags();
    logic b, a;
    logic [W-1:0] v;
    wr(3'd0, 0);
    wr(3'd1, 32'h400); wr(3'd2, 0); wr(3'd3, 32'h3F);
    beat(32'h400, 0, 0, 0, 2'd0, b, a);
    rd(3'd0, v);
    check("R5", "A CPU flag bit15 set, bit14 clear", v & 32'hC000, 32'h8000);
    beat(32'h400, 0, 0, 0, 2'd1, b, a);
    rd(3'd0, v);
    check("R5", "A peripheral flag bit14 set by DMA", v & 32'hC000, 32'hC000);
    wr(3'd0, 32'h0000_C000);
    rd(3'd0, v);
    check("R6", "writing 1 keeps flags", v & 32'hC000, 32'hC000);
    wr(3'd0, 32'h0000_4000);
    rd(3'd0, v);
    check("R6", "writing 0 clears only bit15", v & 32'hC000, 32'h4000);
    wr(3'd0, 0);
  endtask

  task automatic t_ext();
    logic b, a;
    logic [W-1:0] v;
    wr(3'd0, 0);
    beat(32'h400, 0, 0, 0, 2'd2, b, a);
    check("R7", "external master ignored when disabled", {31'd0, b}, 0);
    rd(3'd0, v);
    check("R7", "no peripheral flag when disabled", v & 32'h4000, 0);
    wr(3'd0, 32'h0000_2000);
    beat(32'h400, 0, 0, 0, 2'd2, b, a);
    check("R7", "external master breaks when enabled", {31'd0, b}, 1);
    rd(3'd0, v);
    check("R7", "peripheral flag set by external master", v & 32'h4000, 32'h4000);
    wr(3'd0, 0);
  endtask

  task automatic t_data();
    logic b, a;
    logic [W-1:0] v;
    wr(3'd3, 0);
    wr(3'd4, 32'h2000); wr(3'd5, 0); wr(3'd6, 32'h3F); wr(3'd7, 32'hDEAD_BEEF);
    wr(3'd0, 32'h0000_0002);
    beat(32'h2000, 32'h1234, 1, 0, 2'd0, b, a);
    check("R8", "data mismatch blocks B", {31'd0, b}, 0);
    beat(32'h2000, 32'hDEAD_BEEF, 1, 0, 2'd0, b, a);
    check("R8", "data match lets B break", {31'd0, b}, 1);
    rd(3'd0, v);
    check("R5", "B CPU flag bit12 set", v & 32'h1800, 32'h1000);
    wr(3'd0, 0);
    beat(32'h2000, 32'h1234, 1, 0, 2'd0, b, a);
    check("R8", "data ignored when compare off", {31'd0, b}, 1);
  endtask

  task automatic t_seq();
    logic b, a;
    wr(3'd1, 32'h100); wr(3'd2, 0); wr(3'd3, 32'h3F);
    wr(3'd0, 32'h0000_0008);
    beat(32'h2000, 0, 0, 0, 2'd0, b, a);
    check("R9", "B before A raises no break", {31'd0, b}, 0);
    beat(32'h100, 0, 0, 0, 2'd0, b, a);
    check("R9", "A alone raises no break", {31'd0, b}, 0);
    beat(32'h2000, 0, 0, 0, 2'd0, b, a);
    check("R9", "B after A breaks", {31'd0, b}, 1);
    beat(32'h2000, 0, 0, 0, 2'd0, b, a);
    check("R9", "sequence disarmed after break", {31'd0, b}, 0);
    beat(32'h100, 0, 0, 0, 2'd0, b, a);
    wr(3'd0, 32'h0000_0008);
    beat(32'h2000, 0, 0, 0, 2'd0, b, a);
    check("R9", "control write disarms", {31'd0, b}, 0);
  endtask

  task automatic t_fetch();
    logic b, a;
    wr(3'd0, 32'h0000_0004);
    beat(32'h100, 0, 0, 1, 2'd0, b, a);
    check("R10", "fetch break flagged after", {30'd0, b, a}, 2'b11);
    beat(32'h100, 0, 0, 0, 2'd0, b, a);
    check("R10", "data break not flagged after", {30'd0, b, a}, 2'b10);
    wr(3'd0, 0);
    beat(32'h100, 0, 0, 1, 2'd0, b, a);
    check("R10", "fetch break before when bit2 clear", {30'd0, b, a}, 2'b10);
  endtask

  task automatic t_legacy();
    logic b, a;
    wr(3'd0, 32'h0000_000B);
    beat(32'h2000, 32'h5555, 0, 0, 2'd0, b, a);
    check("R11", "legacy: B breaks unarmed, data ignored", {31'd0, b}, 1);
    wr(3'd0, 0);
  endtask

  task automatic t_mrst();
    logic b, a;
    logic [W-1:0] v;
    wr(3'd0, 32'h0000_0008);
    beat(32'h100, 0, 0, 0, 2'd0, b, a);
    @(negedge clk) mrst_n = 1'b0;
    @(negedge clk) mrst_n = 1'b1;
    rd(3'd0, v);
    check("R1", "manual reset keeps control", v, 32'h0000_8008);
    beat(32'h2000, 0, 0, 0, 2'd0, b, a);
    check("R1", "manual reset discards arm", {31'd0, b}, 0);
    wr(3'd0, 0);
  endtask

  task automatic t_novalid();
    logic [W-1:0] v;
    wr(3'd0, 0);
    @(negedge clk);
    mon_valid = 1'b0; mon_addr = 32'h100; mon_master = 2'd0; mon_fetch = 1'b0;
    @(posedge clk); #1
    check("R12", "idle beat raises no break", {31'd0, brk_req}, 0);
    rd(3'd0, v);
    check("R12", "idle beat sets no flag", v & 32'hD800, 0);
  endtask

  initial begin
    t_reset();
    t_mask();
    t_fields();
    t_flags();
    t_ext();
    t_data();
    t_seq();
    t_fetch();
    t_legacy();
    t_mrst();
    t_novalid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule